// File: doc/BRIEF.md
# Ten-Line Interrupt Aggregator

This block gathers ten external interrupt request lines into a single active-low interrupt output for a host processor. Each request line first passes through a two-flop synchroniser. A per-line detector then watches it for the trigger kind chosen for that line: falling edge, rising edge, both edges, low level or high level. A qualifying event sets a sticky status bit. The output is asserted whenever any status bit is set and its mask bit is clear.

The host programs the block through a flat 16-bit register port that completes each access in one cycle. Writes take effect on the clock edge. Reads are combinational from the address. The registers are status, mask, two trigger-control words, a peripheral reset word and a read-only identity word.

The output is meant for a host that reacts only to edges. The host can therefore force the output inactive by masking every line and then restore its mask. Any source that is still pending and unmasked then produces a fresh falling edge.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status reads 0x0000, the mask reads 0xFFFF, both trigger-control words read 0x0000, the peripheral reset word reads 0x0000 (all peripherals held in reset), and `irq_out_n` is 1.
- R2: A qualifying change on a request line appears in the status register after the third rising clock edge that follows the change. Two of those edges are the synchroniser and one is the status flop.
- R3: Trigger code 1 latches on a falling edge, code 4 on a rising edge and code 5 on either edge. An edge of the opposite direction does not latch.
- R4: Code 2 (active low) and code 3 (active high) set the status bit in every cycle the level is active. A set in the same cycle as a clear wins, so the bit cannot be cleared while the level persists.
- R5: Codes 0, 6 and 7 disable a line, so its status bit never sets.
- R6: The trigger code of line n sits in bits [3n+2:3n] of the control word at offset 2 for n = 0..4. For n = 5..9 it sits in bits [3(n-5)+2:3(n-5)] of the control word at offset 3. Both words read back as written.
- R7: A write to the status register at offset 0 clears each status bit whose written bit is 0. Bits written as 1 are left unchanged.
- R8: The mask register is at offset 1, and a mask bit of 1 masks its line. Masked lines still latch status. `irq_out_n` is 0 exactly when some status bit has a 0 mask bit, so unmasking an already-pending line asserts the output in the cycle after the write.
- R9: Writing 0xFFFF to the mask drives `irq_out_n` to 1 in the cycle after the write. Writing back a mask that leaves a pending line unmasked drives it to 0 in the cycle after that write.
- R10: Offset 5 reads {BOARD_ID, REVISION} (board number in bits 15:8, revision in bits 7:0). Writes to it have no effect.
- R11: The word at offset 4 drives `periph_rst_n` in the cycle after the write. A 0 bit holds that peripheral in reset and a 1 bit releases it.
- R12: Status bits 15:10 always read 0, and offsets 6 and 7 read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 10 | Asynchronous interrupt request lines |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq_out_n | output | 1 | Combined interrupt, active low |
| periph_rst_n | output | 16 | Per-peripheral reset lines, active low |

## Verification
A wrong internal state shows at two places. A stuck or lost status bit appears at the status read and on `irq_out_n` within three edges of the input change. A mask or control word that went wrong appears on its readback and in the cycle right after the write. The bench drives each trigger code with a qualifying and a non-qualifying transition, then samples exactly three edges later. The mask-all and restore sequence is checked cycle by cycle, so a registered or delayed output path would be caught. A clear that loses against a level set would be caught the same way, as would a wrong field position.

// File: rtl/irq_agg_pkg.sv
// Package: irq_agg_pkg
// Shared register offsets and trigger codes for the interrupt aggregator.
// Assumes a 3-bit trigger field per line; codes not listed mean disabled.
package irq_agg_pkg;
    localparam int OFF_STATUS  = 0;
    localparam int OFF_MASK    = 1;
    localparam int OFF_CTRL0   = 2;
    localparam int OFF_RESET   = 4;
    localparam int OFF_VERSION = 5;

    localparam int TRIG_W = 3;

    localparam logic [TRIG_W-1:0] TRIG_OFF  = 3'd0;
    localparam logic [TRIG_W-1:0] TRIG_FALL = 3'd1;
    localparam logic [TRIG_W-1:0] TRIG_LOW  = 3'd2;
    localparam logic [TRIG_W-1:0] TRIG_HIGH = 3'd3;
    localparam logic [TRIG_W-1:0] TRIG_RISE = 3'd4;
    localparam logic [TRIG_W-1:0] TRIG_BOTH = 3'd5;
endpackage

// File: rtl/irq_sync_bank.sv
// Module: irq_sync_bank
// Brings a vector of asynchronous request lines into the clock domain
// through a chain of STAGES flops per bit. Assumes each line is a slow
// level signal, so every bit may be synchronised on its own.
module irq_sync_bank #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_trigger_detect.sv
// Module: irq_trigger_detect
// Turns one synchronised request line into a one-cycle set request
// according to its trigger code. Edge codes pulse on the transition.
// Level codes hold the request high while the level is active.
// Assumes the input is already synchronised to clk.
module irq_trigger_detect
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_sync,
    input  logic [TRIG_W-1:0] trig_code,
    output logic              set_req
);
    logic line_prev_q;
    logic rise;
    logic fall;

    // Remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev_q <= 1'b0;
        end else begin
            line_prev_q <= line_sync;
        end
    end

    assign rise = line_sync & ~line_prev_q;
    assign fall = ~line_sync & line_prev_q;

    // Select the event that matches the programmed trigger code.
    always_comb begin
        case (trig_code)
            TRIG_FALL: set_req = fall;
            TRIG_RISE: set_req = rise;
            TRIG_BOTH: set_req = rise | fall;
            TRIG_LOW:  set_req = ~line_sync;
            TRIG_HIGH: set_req = line_sync;
            default:   set_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: irq_aggregator
// Merges NUM_SRC interrupt lines into one active-low output. Each line
// has a programmable trigger, a sticky status bit and a mask bit. The
// host uses a single-cycle register port: writes land on the clock edge
// and reads are combinational from the address. Assumes reg_we is a
// one-cycle strobe and that NUM_SRC does not exceed DATA_W.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int          NUM_SRC  = 10,
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 3,
    parameter int          SYNC_STG = 2,
    parameter logic [7:0]  BOARD_ID = 8'h2A,
    parameter logic [7:0]  REVISION = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out_n,
    output logic [DATA_W-1:0] periph_rst_n
);
    localparam int PER_WORD = DATA_W / TRIG_W;
    localparam int NUM_CTRL = (NUM_SRC + PER_WORD - 1) / PER_WORD;

    logic [NUM_SRC-1:0]             req_sync;
    logic [NUM_SRC-1:0]             set_vec;
    logic [NUM_SRC-1:0]             status_q;
    logic [DATA_W-1:0]              mask_q;
    logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0]              rst_q;
    logic                           wr_status;

    irq_sync_bank #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STG)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_req),
        .sync_out (req_sync)
    );

    // One trigger detector per line, its code picked from the packed words.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_det
        localparam int WORD  = n / PER_WORD;
        localparam int SHIFT = TRIG_W * (n % PER_WORD);
        irq_trigger_detect det_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_sync (req_sync[n]),
            .trig_code (ctrl_q[WORD][SHIFT +: TRIG_W]),
            .set_req   (set_vec[n])
        );
    end

    assign wr_status = reg_we && (reg_addr == ADDR_W'(OFF_STATUS));

    // Sticky status: a write clears the bits written as 0, and a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (wr_status) begin
            status_q <= (status_q & reg_wdata[NUM_SRC-1:0]) | set_vec;
        end else begin
            status_q <= status_q | set_vec;
        end
    end

    // Mask and peripheral reset words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            rst_q  <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(OFF_MASK)) begin
                mask_q <= reg_wdata;
            end
            if (reg_addr == ADDR_W'(OFF_RESET)) begin
                rst_q <= reg_wdata;
            end
        end
    end

    // Trigger-control words at consecutive offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CTRL; i++) begin
                if (reg_we && (reg_addr == ADDR_W'(OFF_CTRL0 + i))) begin
                    ctrl_q[i] <= reg_wdata;
                end
            end
        end
    end

    // Read multiplexer; unused offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFF_STATUS))  reg_rdata = DATA_W'(status_q);
        if (reg_addr == ADDR_W'(OFF_MASK))    reg_rdata = mask_q;
        if (reg_addr == ADDR_W'(OFF_RESET))   reg_rdata = rst_q;
        if (reg_addr == ADDR_W'(OFF_VERSION)) reg_rdata = DATA_W'({BOARD_ID, REVISION});
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (reg_addr == ADDR_W'(OFF_CTRL0 + i)) reg_rdata = ctrl_q[i];
        end
    end

    // Combined output: low while any unmasked line is pending.
    assign irq_out_n    = ~|(status_q & ~mask_q[NUM_SRC-1:0]);
    assign periph_rst_n = rst_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: irq_aggregator_chk
// Port-level properties of the aggregator, bound to every instance.
// Assumes the default offset map from irq_agg_pkg.
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int         DATA_W   = 16,
    parameter int         ADDR_W   = 3,
    parameter logic [7:0] BOARD_ID = 8'h2A,
    parameter logic [7:0] REVISION = 8'h13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_out_n,
    input logic [DATA_W-1:0] periph_rst_n
);
    // R9: masking everything quiets the output on the next cycle.
    a_r9_mask_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFF_MASK) && reg_wdata == '1) |=> irq_out_n);

    // R11: the reset word follows the written value.
    a_r11_reset_word: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFF_RESET)) |=> (periph_rst_n == $past(reg_wdata)));

    // R10: the identity word never changes.
    a_r10_version_const: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFF_VERSION)) |-> (reg_rdata == DATA_W'({BOARD_ID, REVISION})));

    // R12: upper status bits always read zero.
    a_r12_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFF_STATUS)) |-> (reg_rdata[DATA_W-1:10] == '0));

    // R11: the reset word is stable when not written.
    a_r11_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_W'(OFF_RESET)) |=> $stable(periph_rst_n));
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .BOARD_ID (BOARD_ID),
    .REVISION (REVISION)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_out_n    (irq_out_n),
    .periph_rst_n (periph_rst_n)
);

// File: tb/irq_aggregator_tb_top.sv
// Bench for irq_aggregator: a table of per-line trigger vectors, then
// directed tests for reset, clearing, masking and the register words.
module irq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  irq_req = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out_n;
    logic [15:0] periph_rst_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_req      (irq_req),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_out_n    (irq_out_n),
        .periph_rst_n (periph_rst_n)
    );

    // Vector: {line[3:0], code[2:0], start level, end level, expect latch}
    localparam int NV = 11;
    localparam logic [9:0] VECS [NV] = '{
        {4'd0, 3'd1, 1'b1, 1'b0, 1'b1},   // R3 falling, falling edge
        {4'd1, 3'd1, 1'b0, 1'b1, 1'b0},   // R3 falling, rising edge
        {4'd2, 3'd4, 1'b0, 1'b1, 1'b1},   // R3 rising, rising edge
        {4'd3, 3'd4, 1'b1, 1'b0, 1'b0},   // R3 rising, falling edge
        {4'd4, 3'd5, 1'b0, 1'b1, 1'b1},   // R3 both, rising
        {4'd5, 3'd5, 1'b1, 1'b0, 1'b1},   // R3 both, falling
        {4'd6, 3'd2, 1'b1, 1'b0, 1'b1},   // R4 low level
        {4'd7, 3'd3, 1'b0, 1'b1, 1'b1},   // R4 high level
        {4'd8, 3'd6, 1'b0, 1'b1, 1'b0},   // R5 code 6
        {4'd9, 3'd0, 1'b0, 1'b1, 1'b0},   // R5 code 0
        {4'd9, 3'd7, 1'b1, 1'b0, 1'b0}    // R5 code 7
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [15:0] v;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(1);

        // R1 reset state
        rd(3'd0, v); check("R1 status", v, 16'h0000);
        rd(3'd1, v); check("R1 mask", v, 16'hFFFF);
        rd(3'd2, v); check("R1 ctrl lo", v, 16'h0000);
        rd(3'd3, v); check("R1 ctrl hi", v, 16'h0000);
        rd(3'd4, v); check("R1 reset word", v, 16'h0000);
        check("R1 irq_out_n", {15'd0, irq_out_n}, 16'h0001);

        // Vector loop: R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            int          line;
            logic [2:0]  code;
            logic [2:0]  caddr;
            int          sh;
            line  = int'(VECS[k][9:6]);
            code  = VECS[k][5:3];
            caddr = (line < 5) ? 3'd2 : 3'd3;
            sh    = 3 * (line % 5);
            wr(3'd2, 16'h0000);
            wr(3'd3, 16'h0000);
            irq_req = '0;
            irq_req[line] = VECS[k][2];
            wait_clks(4);
            wr(caddr, 16'(code) << sh);
            wr(3'd1, ~(16'h1 << line));
            wait_clks(4);
            wr(3'd0, 16'h0000);
            irq_req[line] = VECS[k][1];
            wait_clks(3);
            rd(3'd0, v);
            check("R2/R3/R4/R5/R6 status", v, VECS[k][0] ? (16'h1 << line) : 16'h0000);
            check("R8 output", {15'd0, irq_out_n}, {15'd0, ~VECS[k][0]});
        end

        // R6 control readback and field layout
        wr(3'd3, 16'h7000);
        rd(3'd3, v); check("R6 ctrl hi readback", v, 16'h7000);
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h0000);
        irq_req = '0;
        wait_clks(4);

        // R8: masked line still latches; unmask asserts output
        wr(3'd1, 16'hFFFF);
        irq_req[0] = 1'b1;
        irq_req[1] = 1'b0;
        wr(3'd2, 16'h0021);   // line 0 falling, line 1 rising
        wait_clks(4);
        wr(3'd0, 16'h0000);
        irq_req[0] = 1'b0;
        wait_clks(3);
        rd(3'd0, v); check("R8 masked latch", v, 16'h0001);
        check("R8 masked output idle", {15'd0, irq_out_n}, 16'h0001);
        wr(3'd1, 16'hFFFE);
        check("R8 unmask asserts", {15'd0, irq_out_n}, 16'h0000);

        // R9 mask-all and restore
        wr(3'd1, 16'hFFFF);
        check("R9 mask all", {15'd0, irq_out_n}, 16'h0001);
        wr(3'd1, 16'hFFFE);
        check("R9 restore", {15'd0, irq_out_n}, 16'h0000);

        // R7 selective clear
        irq_req[1] = 1'b1;
        wait_clks(3);
        rd(3'd0, v); check("R2 second line", v, 16'h0003);
        wr(3'd0, 16'hFFFE);
        rd(3'd0, v); check("R7 clear one", v, 16'h0002);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); check("R7 ones keep", v, 16'h0002);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); check("R7 clear all", v, 16'h0000);

        // R4 level persists through a clear
        irq_req[2] = 1'b1;
        wait_clks(3);
        wr(3'd2, 16'h0080);   // line 2 low level
        irq_req[2] = 1'b0;
        wait_clks(3);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); check("R4 set beats clear", v, 16'h0004);
        irq_req[2] = 1'b1;
        wait_clks(3);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); check("R4 clear after release", v, 16'h0000);

        // R10 identity is read-only
        rd(3'd5, v); check("R10 version", v, 16'h2A13);
        wr(3'd5, 16'h0000);
        rd(3'd5, v); check("R10 write ignored", v, 16'h2A13);

        // R11 reset word
        wr(3'd4, 16'h0005);
        check("R11 reset lines", periph_rst_n, 16'h0005);

        // R12 unused reads
        rd(3'd6, v); check("R12 offset 6", v, 16'h0000);
        rd(3'd7, v); check("R12 offset 7", v, 16'h0000);
        rd(3'd1, v); check("R8 mask readback", v, 16'hFFFE);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule